// File: doc/BRIEF.md
# Macro Call Parameter Collector

This block sits on the method-write port of a graphics command processor. Each write carries a method index, a 32-bit word and a flag that marks the last word of its command packet. A method index below the trigger threshold (0xE00 by default) is an ordinary register write. The block passes it straight on to the register file in the same cycle. A method at or above the threshold triggers a macro. Such writes never reach the register file. Their words are gathered into a parameter FIFO, and the macro's code is launched only when the packet ends.

Macros occupy pairs of methods. The even method of a pair opens a call and the odd method that follows it carries further arguments. The macro's entry number is half the distance from the threshold. When a call closes, the block looks the entry up in a bind table. If the entry is bound, the block raises a start request to the macro executor, carrying the code offset and the number of parameters. The executor then drains the FIFO through a pop port.

A few ordinary methods also drive local state:
- One method sets the code upload pointer.
- One method writes a code word into local instruction storage at that pointer.
- One method selects a bind table entry.
- One method binds a code offset to the selected entry.

Top module: `macro_param_collector`

## Requirements
- R1: While no call is open, an accepted write with a method below 0xE00 appears in the same cycle on `reg_we`/`reg_addr`/`reg_wdata`. A method at or above 0xE00 never does.
- R2: While idle, an even trigger method opens a call and its word is queued. An odd trigger method is dropped and sets `err_flags[0]`.
- R3: While a call is open, any method other than the opening method plus one is dropped, is not forwarded, leaves the call unchanged, and sets the sticky `err_flags[0]`.
- R4: Every legal trigger word, the first one included, enters the parameter FIFO in arrival order. `prm_data` shows the oldest word whenever `prm_empty` is low, and `prm_pop` removes it.
- R5: An accepted legal trigger word with `in_last` high closes the call. In the next cycle `start_valid` rises with `start_offset` equal to the offset bound to entry (method − 0xE00) >> 1, and `start_count` equal to the number of words the call stored.
- R6: While `start_valid` is high, `in_ready` is low and no write is taken. `start_valid`, `start_offset` and `start_count` hold until `start_ready`.
- R7: Closing a call on an entry that was never bound, or that lies beyond the table, raises no request. It sets the sticky `err_flags[3]` and empties the parameter FIFO.
- R8: The FIFO holds 32 words. A trigger word that arrives while it is full is dropped, sets the sticky `err_flags[1]`, and is not counted in `start_count`.
- R9: A write to method 0x045 sets the upload pointer. A write to method 0x046 stores its word at the pointer and then increments the pointer. The stored word is readable on `code_rd_data` at `code_rd_addr` in the same cycle.
- R10: An upload data write while the pointer is 64 or more stores nothing, leaves the pointer unchanged, and sets the sticky `err_flags[2]`.
- R11: A write to method 0x047 selects entry `in_data[3:0]`. A write to method 0x048 binds offset `in_data[5:0]` to the selected entry.
- R12: After reset, `in_ready` is 1, `start_valid` is 0, `err_flags` is 0, the FIFO is empty, no entry is bound and the upload pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A method write is offered |
| in_ready | output | 1 | The block can take a write this cycle |
| in_method | input | 13 | Method index |
| in_data | input | 32 | Method argument word |
| in_last | input | 1 | Marks the last word of the command packet |
| reg_we | output | 1 | Ordinary register write strobe |
| reg_addr | output | 13 | Ordinary register index |
| reg_wdata | output | 32 | Ordinary register data |
| start_valid | output | 1 | Macro start request pending |
| start_ready | input | 1 | The executor accepts the request |
| start_offset | output | 6 | Code offset of the macro |
| start_count | output | 6 | Number of parameter words in the FIFO for this call |
| prm_pop | input | 1 | Removes the oldest parameter word |
| prm_data | output | 32 | Oldest parameter word |
| prm_empty | output | 1 | The parameter FIFO is empty |
| code_rd_addr | input | 6 | Code storage read address |
| code_rd_data | output | 32 | Code word at `code_rd_addr` |
| err_flags | output | 4 | Sticky errors: [0] call sequence, [1] FIFO overflow, [2] upload range, [3] unbound entry |

## Verification
The hidden state is limited: whether a call is open, which method opened it, the call's word count, the FIFO pointers, the upload pointer and the bind table. A wrong call state shows in the first cycle of the next write: a word is forwarded that should have been dropped, or an error bit appears. A wrong count or offset shows on `start_count` or `start_offset` one cycle after the closing word. A wrong FIFO pointer shows on `prm_data` or `prm_empty` the cycle after the faulty push or pop. A wrong upload pointer shows on `code_rd_data` one cycle after the next code write.

// File: rtl/macro_pc_pkg.sv
// Shared definitions for the macro call parameter collector.
// Assumes nothing beyond the parameter defaults of the top module.
package macro_pc_pkg;
    localparam int ERR_N   = 4;
    localparam int ERR_SEQ = 0;   // illegal method order around a call
    localparam int ERR_OVF = 1;   // parameter FIFO overflow
    localparam int ERR_UPL = 2;   // code upload beyond storage
    localparam int ERR_NF  = 3;   // launch of an unbound entry

    typedef enum logic {
        CALL_IDLE = 1'b0,
        CALL_OPEN = 1'b1
    } call_state_e;
endpackage

// File: rtl/mpc_param_fifo.sv
// Parameter FIFO: stores the words of macro calls in arrival order and
// presents the oldest one at the head. It assumes DEPTH is a power of two.
// A push while full is ignored; the caller flags that case. Flush wins over
// push and pop in the same cycle.
module mpc_param_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign head    = mem[rd_ptr];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    // Storage write; no reset is needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(do_push);
            rd_ptr <= rd_ptr + AW'(do_pop);
            fill   <= fill + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/mpc_code_store.sv
// Macro code storage with an upload pointer that increments after each
// write. It assumes addr_we and data_we are never high together. A data
// write at a pointer of DEPTH or more is discarded and reported.
module mpc_code_store #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic [W-1:0]  addr_val,
    input  logic          data_we,
    input  logic [W-1:0]  data_val,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          range_err
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] ptr;

    assign range_err = data_we && (ptr >= W'(DEPTH));
    assign rd_data   = mem[rd_addr];

    // Code word write at the upload pointer.
    always_ff @(posedge clk) begin
        if (data_we && !range_err) mem[ptr[AW-1:0]] <= data_val;
    end

    // Upload pointer: loaded explicitly, advanced after each stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ptr <= '0;
        else if (addr_we)               ptr <= addr_val;
        else if (data_we && !range_err) ptr <= ptr + W'(1);
    end
endmodule

// File: rtl/mpc_bind_table.sv
// Bind table: maps a macro entry number to a code offset. An entry counts as
// bound only after its first bind write. The selected entry for the next
// bind write is kept here. The lookup is combinational.
module mpc_bind_table #(
    parameter int ENTRIES = 16,
    parameter int OFS_W   = 6,
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [ENT_W-1:0] sel_val,
    input  logic             bind_we,
    input  logic [OFS_W-1:0] bind_ofs,
    input  logic [ENT_W-1:0] lk_idx,
    output logic             lk_hit,
    output logic [OFS_W-1:0] lk_ofs
);
    logic [ENT_W-1:0] sel;
    logic [ENTRIES-1:0] bound;
    logic [OFS_W-1:0] ofs [ENTRIES];

    // Entry selection register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= '0;
        else if (sel_we) sel <= sel_val;
    end

    // One slot per entry: a bound bit with reset and an offset without reset.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                bound[e] <= 1'b0;
            else if (bind_we && sel == ENT_W'(e))      bound[e] <= 1'b1;
        end
        always_ff @(posedge clk) begin
            if (bind_we && sel == ENT_W'(e)) ofs[e] <= bind_ofs;
        end
    end

    assign lk_hit = bound[lk_idx];
    assign lk_ofs = ofs[lk_idx];
endmodule

// File: rtl/macro_param_collector.sv
// Macro call parameter collector. It splits method writes into ordinary
// register writes and macro trigger words, gathers the trigger words of a
// call, and raises a start request when the packet ends. It assumes
// TRIG_BASE is even and that METHOD_W is wider than the entry index.
// All method writes are held off while a start request is pending.
module macro_param_collector
    import macro_pc_pkg::*;
#(
    parameter int          METHOD_W     = 13,
    parameter int          DATA_W       = 32,
    parameter int unsigned TRIG_BASE    = 'hE00,
    parameter int          PFIFO_DEPTH  = 32,
    parameter int          CODE_DEPTH   = 64,
    parameter int          BIND_ENTRIES = 16,
    parameter int unsigned M_UPL_ADDR   = 'h045,
    parameter int unsigned M_UPL_DATA   = 'h046,
    parameter int unsigned M_BIND_SEL   = 'h047,
    parameter int unsigned M_BIND_OFS   = 'h048,
    localparam int CNT_W   = $clog2(PFIFO_DEPTH + 1),
    localparam int CODE_AW = $clog2(CODE_DEPTH),
    localparam int ENT_W   = $clog2(BIND_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [METHOD_W-1:0] in_method,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_last,
    output logic                reg_we,
    output logic [METHOD_W-1:0] reg_addr,
    output logic [DATA_W-1:0]   reg_wdata,
    output logic                start_valid,
    input  logic                start_ready,
    output logic [CODE_AW-1:0]  start_offset,
    output logic [CNT_W-1:0]    start_count,
    input  logic                prm_pop,
    output logic [DATA_W-1:0]   prm_data,
    output logic                prm_empty,
    input  logic [CODE_AW-1:0]  code_rd_addr,
    output logic [DATA_W-1:0]   code_rd_data,
    output logic [ERR_N-1:0]    err_flags
);
    localparam logic [METHOD_W-1:0] BASE_M  = METHOD_W'(TRIG_BASE);
    localparam logic [METHOD_W-1:0] ENT_LIM = METHOD_W'(BIND_ENTRIES);

    call_state_e         st;
    logic [METHOD_W-1:0] cur_m;
    logic [CNT_W-1:0]    call_cnt, words_now;
    logic                accept, busy, is_trig, start_ok, arg_ok, seq_bad, plain;
    logic                take, stored, ovf, fire, hit, miss, upl_err, fifo_full;
    logic [METHOD_W-1:0] rel, ent_rel;
    logic                lk_hit;
    logic [CODE_AW-1:0]  lk_ofs;

    // Classification of the write offered this cycle.
    assign in_ready  = !start_valid;
    assign accept    = in_valid && in_ready;
    assign busy      = (st == CALL_OPEN);
    assign is_trig   = (in_method >= BASE_M);
    assign start_ok  = accept && !busy && is_trig && !in_method[0];
    assign arg_ok    = accept && busy && (in_method == cur_m + METHOD_W'(1));
    assign seq_bad   = accept && ((busy && !arg_ok) || (!busy && is_trig && in_method[0]));
    assign plain     = accept && !busy && !is_trig;
    assign take      = start_ok || arg_ok;
    assign stored    = take && !fifo_full;
    assign ovf       = take && fifo_full;
    assign fire      = take && in_last;
    assign rel       = in_method - BASE_M;
    assign ent_rel   = rel >> 1;
    assign hit       = (ent_rel < ENT_LIM) && lk_hit;
    assign miss      = fire && !hit;
    assign words_now = (start_ok ? '0 : call_cnt) + CNT_W'(stored);

    // Ordinary writes go straight to the register file.
    assign reg_we    = plain;
    assign reg_addr  = in_method;
    assign reg_wdata = in_data;

    mpc_param_fifo #(.DEPTH(PFIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(stored), .push_data(in_data),
        .pop(prm_pop), .flush(miss), .head(prm_data), .empty(prm_empty),
        .full(fifo_full)
    );

    mpc_code_store #(.DEPTH(CODE_DEPTH), .W(DATA_W)) u_code (
        .clk(clk), .rst_n(rst_n),
        .addr_we(plain && in_method == METHOD_W'(M_UPL_ADDR)), .addr_val(in_data),
        .data_we(plain && in_method == METHOD_W'(M_UPL_DATA)), .data_val(in_data),
        .rd_addr(code_rd_addr), .rd_data(code_rd_data), .range_err(upl_err)
    );

    mpc_bind_table #(.ENTRIES(BIND_ENTRIES), .OFS_W(CODE_AW)) u_bind (
        .clk(clk), .rst_n(rst_n),
        .sel_we(plain && in_method == METHOD_W'(M_BIND_SEL)), .sel_val(in_data[ENT_W-1:0]),
        .bind_we(plain && in_method == METHOD_W'(M_BIND_OFS)), .bind_ofs(in_data[CODE_AW-1:0]),
        .lk_idx(ent_rel[ENT_W-1:0]), .lk_hit(lk_hit), .lk_ofs(lk_ofs)
    );

    // Call state: opened by an even trigger, closed by the packet's last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= CALL_IDLE;
            cur_m    <= '0;
            call_cnt <= '0;
        end else begin
            if (fire)          st <= CALL_IDLE;
            else if (start_ok) st <= CALL_OPEN;
            if (start_ok) cur_m <= in_method;
            if (take)     call_cnt <= words_now;
        end
    end

    // Start request: raised on a bound launch, held until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_valid  <= 1'b0;
            start_offset <= '0;
            start_count  <= '0;
        end else if (fire && hit) begin
            start_valid  <= 1'b1;
            start_offset <= lk_ofs;
            start_count  <= words_now;
        end else if (start_ready) begin
            start_valid  <= 1'b0;
        end
    end

    // Sticky error collection.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flags <= '0;
        else begin
            if (seq_bad) err_flags[ERR_SEQ] <= 1'b1;
            if (ovf)     err_flags[ERR_OVF] <= 1'b1;
            if (upl_err) err_flags[ERR_UPL] <= 1'b1;
            if (miss)    err_flags[ERR_NF]  <= 1'b1;
        end
    end
endmodule

// File: rtl/macro_param_collector_chk.sv
// Port-level checker for the macro call parameter collector, bound to every
// instance of the top module. It holds only properties and no state.
module macro_param_collector_chk #(
    parameter int          METHOD_W  = 13,
    parameter int          DATA_W    = 32,
    parameter int unsigned TRIG_BASE = 'hE00,
    parameter int          PFIFO_DEPTH = 32,
    parameter int          CNT_W     = 6,
    parameter int          CODE_AW   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_ready,
    input logic                reg_we,
    input logic [METHOD_W-1:0] reg_addr,
    input logic                start_valid,
    input logic                start_ready,
    input logic [CODE_AW-1:0]  start_offset,
    input logic [CNT_W-1:0]    start_count,
    input logic [3:0]          err_flags
);
    // R1: trigger methods never reach the register file
    assert_no_trig_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_addr < METHOD_W'(TRIG_BASE)));

    // R6: writes are held off while a request is pending
    assert_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> !in_ready);

    // R6: request and payload hold until accepted
    assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !start_ready) |=> (start_valid && $stable(start_offset) && $stable(start_count)));

    // R5: an accepted request cannot be followed at once by another
    assert_single_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_ready) |=> !start_valid);

    // R8: a launched call carries between one and DEPTH words
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> (start_count >= CNT_W'(1) && start_count <= CNT_W'(PFIFO_DEPTH)));

    // R3: error bits never clear outside reset
    assert_errors_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags & $past(err_flags)) == $past(err_flags));
endmodule

bind macro_param_collector macro_param_collector_chk #(
    .METHOD_W(METHOD_W), .DATA_W(DATA_W), .TRIG_BASE(TRIG_BASE),
    .PFIFO_DEPTH(PFIFO_DEPTH), .CNT_W(CNT_W), .CODE_AW(CODE_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .reg_we(reg_we), .reg_addr(reg_addr),
    .start_valid(start_valid), .start_ready(start_ready), .start_offset(start_offset),
    .start_count(start_count), .err_flags(err_flags)
);

// File: tb/macro_param_collector_test.sv
`timescale 1ns/1ps
// Bench for the macro call parameter collector. A behavioural model built
// from queues and arrays predicts every output, and the outputs are compared
// with it in every clock cycle.
module macro_param_collector_test;
    localparam int BASE = 'hE00;
    localparam logic [12:0] UPA = 13'h045, UPD = 13'h046, BSEL = 13'h047, BOFS = 13'h048;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        in_valid = 0, in_last = 0, start_ready = 1, prm_pop = 0;
    logic [12:0] in_method = '0;
    logic [31:0] in_data = '0;
    logic [5:0]  code_rd_addr = '0;
    logic        in_ready, reg_we, start_valid, prm_empty;
    logic [12:0] reg_addr;
    logic [31:0] reg_wdata, prm_data, code_rd_data;
    logic [5:0]  start_offset, start_count;
    logic [3:0]  err_flags;

    macro_param_collector uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_method(in_method), .in_data(in_data), .in_last(in_last),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_offset(start_offset), .start_count(start_count),
        .prm_pop(prm_pop), .prm_data(prm_data), .prm_empty(prm_empty),
        .code_rd_addr(code_rd_addr), .code_rd_data(code_rd_data), .err_flags(err_flags)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Model state
    bit          m_busy = 0, m_sv = 0;
    int          m_cur = 0, m_cnt = 0, m_so = 0, m_sc = 0, m_sel = 0;
    logic [31:0] m_q[$];
    logic [31:0] m_ram [64];
    bit          m_ramw [64];
    bit          m_bound [16];
    int          m_ofs [16];
    longint      m_upl = 0;
    logic [3:0]  m_err = '0;
    bit          g_pop = 0, g_sr = 1;
    int          g_ra = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare against the model, then advance the model.
    task automatic cyc(input bit v, input logic [12:0] m, input logic [31:0] d, input bit l);
        bit acc, we, full_pre, take, st, stored;
        int ent, cnt;
        @(negedge clk);
        in_valid = v; in_method = m; in_data = d; in_last = l;
        prm_pop = g_pop; start_ready = g_sr; code_rd_addr = 6'(g_ra);
        #1;
        acc = v && !m_sv;
        we  = acc && !m_busy && (int'(m) < BASE);
        check(in_ready == !m_sv, "R6", "in_ready", 32'(in_ready), 32'(!m_sv));
        check(reg_we == we, "R1", "reg_we", 32'(reg_we), 32'(we));
        if (we) check(reg_addr == m && reg_wdata == d, "R1", "reg_wdata", reg_wdata, d);
        check(start_valid == m_sv, "R5", "start_valid", 32'(start_valid), 32'(m_sv));
        if (m_sv) begin
            check(start_offset == 6'(m_so), "R5/R11", "start_offset", 32'(start_offset), 32'(m_so));
            check(start_count == 6'(m_sc), "R5/R8", "start_count", 32'(start_count), 32'(m_sc));
        end
        check(err_flags == m_err, "R2/R3/R7/R8/R10", "err_flags", 32'(err_flags), 32'(m_err));
        check(prm_empty == (m_q.size() == 0), "R4", "prm_empty", 32'(prm_empty), 32'(m_q.size() == 0));
        if (m_q.size() != 0) check(prm_data == m_q[0], "R4", "prm_data", prm_data, m_q[0]);
        if (m_ramw[g_ra]) check(code_rd_data == m_ram[g_ra], "R9", "code_rd_data", code_rd_data, m_ram[g_ra]);
        @(posedge clk);
        full_pre = (m_q.size() >= 32);
        if (g_pop && m_q.size() != 0) void'(m_q.pop_front());
        if (m_sv && g_sr) m_sv = 0;
        if (acc) begin
            take = 0; st = 0;
            if (m_busy) begin
                if (int'(m) == m_cur + 1) take = 1; else m_err[0] = 1;
            end else if (int'(m) >= BASE) begin
                if (m[0]) m_err[0] = 1; else begin take = 1; st = 1; end
            end else begin
                if (m == UPA) m_upl = longint'(d);
                if (m == UPD) begin
                    if (m_upl >= 64) m_err[2] = 1;
                    else begin m_ram[m_upl] = d; m_ramw[m_upl] = 1; m_upl++; end
                end
                if (m == BSEL) m_sel = int'(d[3:0]);
                if (m == BOFS) begin m_bound[m_sel] = 1; m_ofs[m_sel] = int'(d[5:0]); end
            end
            if (take) begin
                stored = !full_pre;
                if (full_pre) m_err[1] = 1; else m_q.push_back(d);
                cnt = (st ? 0 : m_cnt) + int'(stored);
                m_cnt = cnt;
                if (st) begin m_busy = 1; m_cur = int'(m); end
                if (l) begin
                    m_busy = 0;
                    ent = (int'(m) - BASE) >>> 1;
                    if (ent < 16 && m_bound[ent]) begin
                        m_sv = 1; m_so = m_ofs[ent]; m_sc = cnt;
                    end else begin
                        m_err[3] = 1; m_q.delete();
                    end
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0);
    endtask

    task automatic drain();
        g_pop = 1;
        while (m_q.size() != 0) cyc(0, '0, '0, 0);
        g_pop = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_ramw[i] = 0;
        for (int i = 0; i < 16; i++) begin m_bound[i] = 0; m_ofs[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R12: state right after reset
        check(in_ready == 1, "R12", "in_ready", 32'(in_ready), 1);
        check(start_valid == 0, "R12", "start_valid", 32'(start_valid), 0);
        check(err_flags == 0, "R12", "err_flags", 32'(err_flags), 0);
        check(prm_empty == 1, "R12", "prm_empty", 32'(prm_empty), 1);
        idle(2);

        // R1: ordinary writes pass straight through
        cyc(1, 13'h010, 32'hCAFE_0001, 0);
        cyc(1, 13'h1FF, 32'h1234_5678, 1);
        cyc(1, 13'hDFF, 32'hAAAA_5555, 0);

        // R9: upload from pointer 0; R12: pointer starts at 0
        cyc(1, UPD, 32'h0000_00A0, 0);
        cyc(1, UPD, 32'h0000_00A1, 0);
        g_ra = 1; cyc(1, UPD, 32'h0000_00A2, 0);
        g_ra = 2; idle(1);
        // R10: run the pointer off the end
        cyc(1, UPA, 32'd62, 0);
        cyc(1, UPD, 32'hBEEF_003E, 0);
        g_ra = 62; cyc(1, UPD, 32'hBEEF_003F, 0);
        g_ra = 63; cyc(1, UPD, 32'hDEAD_0040, 0);
        idle(1);

        // R11: bind entry 2 to offset 5, entry 0 to offset 9
        cyc(1, BSEL, 32'd2, 0);
        cyc(1, BOFS, 32'd5, 0);
        cyc(1, BSEL, 32'd0, 0);
        cyc(1, BOFS, 32'd9, 0);

        // R4/R5: three-word call on entry 2, executor slow (R6)
        g_sr = 0;
        cyc(1, 13'hE04, 32'h1111_0000, 0);
        cyc(1, 13'hE05, 32'h1111_0001, 0);
        cyc(1, 13'hE05, 32'h1111_0002, 1);
        cyc(1, 13'h020, 32'h0BAD_0BAD, 0);   // R6: refused while pending
        cyc(1, 13'hE00, 32'h0BAD_0BAD, 1);
        g_sr = 1; idle(2);
        drain();

        // R5: single-word call on entry 0
        cyc(1, 13'hE00, 32'h2222_0000, 1);
        idle(2);
        drain();

        // R2: start with an odd method; R3: illegal methods inside a call
        cyc(1, 13'hE01, 32'h3333_0000, 1);
        idle(1);
        cyc(1, 13'hE00, 32'h4444_0000, 0);
        cyc(1, 13'h010, 32'h4444_0BAD, 0);
        cyc(1, 13'hE03, 32'h4444_0BAD, 1);
        cyc(1, 13'hE00, 32'h4444_0BAD, 1);
        cyc(1, 13'hE01, 32'h4444_0001, 1);
        idle(2);
        drain();

        // R7: unbound entry 5, then an entry beyond the table
        cyc(1, 13'hE0A, 32'h5555_0000, 0);
        cyc(1, 13'hE0B, 32'h5555_0001, 1);
        idle(1);
        cyc(1, 13'hE20, 32'h5555_0002, 1);
        idle(1);
        cyc(1, 13'h011, 32'h5555_0003, 0);

        // R8: 34-word call on entry 0 overflows the FIFO
        cyc(1, 13'hE00, 32'h6666_0000, 0);
        for (int i = 1; i < 34; i++) cyc(1, 13'hE01, 32'h6666_0000 + 32'(i), i == 33);
        idle(2);
        drain();
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule